// File: doc/BRIEF.md
# Vector Element Index Remapper

This block produces, one element per clock, the register offsets that a vector operation uses when its elements are reordered. A loop runs over the elements `0 .. vl-1`. Each of up to four operands (operand 0 is the destination, operands 1 to 3 are sources) has its own step counter and may have a shape attached: three dimension sizes, an order code, an offset and a skip bit. With no shape attached, an operand's offset is simply its own step count. With a shape attached, the step walks a three-level odometer in the chosen order. The odometer position is turned into a linear index, wrapped modulo `maxvl`, and the offset is added.

Each element cycle shows the global step number (the value saved for resumption), a destination write enable gated by the predicate mask, every operand's remapped offset, and a per-operand flag raised when base register plus offset falls outside the register file. A loop may start part way through: the block first replays the shape odometers for the skipped steps, then emits the remaining elements.

The controller has four states. IDLE waits for `start`. SEEK replays skipped steps. RUN emits one element per cycle. FINISH raises `done` for one cycle.

The transitions are:
- launch-run: IDLE to RUN, on start with `resume_step` = 0.
- launch-seek: IDLE to SEEK, on start with 0 < `resume_step` < `vl`.
- launch-empty: IDLE to FINISH, on start with `resume_step` >= `vl`.
- seek-end: SEEK to RUN, once the last skipped step is replayed.
- run-end: RUN to FINISH, at the last step or when the destination is scalar.
- retire: FINISH to IDLE.

Top module: `elem_remap`

## Requirements
- R1: After reset, `busy`, `valid` and `done` are low.
- R2: When `start` is sampled with `resume_step` = 0 and a vector destination, `valid` is high from the following cycle for `vl` consecutive cycles. During those cycles `step_save` shows 0 to `vl-1` in turn. Then `done` is high for exactly one cycle with `valid` low, and `busy` then returns low.
- R3: When `is_vec[0]` (the destination) is 0, the loop emits exactly one element and then finishes.
- R4: A source whose `is_vec` bit is 0 keeps step count 0 for the whole loop, so its offset does not change. A source whose bit is 1 advances its step count by one per element.
- R5: An operand with `sh_en` bit 0 gets an offset equal to its own step count.
- R6: A dimension field value d means d+1 positions. Order code 3'b010 steps y innermost, then x, then z. Every other code steps x innermost, then y, then z. The linear index is x + y*(X) + z*(X*Y), where X and Y are the x and y sizes.
- R7: When the skip bit is set, the innermost dimension of the order adds nothing to the linear index. For example, x=4, y=4, order 010 with skip gives 0,0,0,0,1,1,1,1,2,... up to 3.
- R8: The linear index is reduced modulo `maxvl` and the offset field is then added. A shape smaller than `maxvl` simply repeats (x=4, y=1, order 000 gives 0,1,2,3,0,1,...) and raises no error by itself.
- R9: `dst_we` is high in an element cycle exactly when bit `step_save` of `pred` is 1, and it is never high outside element cycles.
- R10: In an element cycle, `bad_reg[k]` is high in that same cycle exactly when `base[k]` plus `idx[k]` is 128 or more. It is low outside element cycles.
- R11: A start with 0 < `resume_step` < `vl` gives `resume_step` cycles with `valid` low. The elements `resume_step` to `vl-1` then follow, with the same offsets a loop from step 0 would have produced at those steps. A start with `resume_step` >= `vl` goes straight to the one `done` cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Launch a loop (sampled in IDLE) |
| resume_step | input | STEP_W | First element step of the loop |
| vl | input | STEP_W | Loop length |
| maxvl | input | STEP_W | Wrap modulus for shaped indices |
| pred | input | MAX_VL | Predicate mask, bit i gates step i |
| is_vec | input | NOPS | Operand k is a vector (bit 0 = destination) |
| base | input | NOPS x REG_W | Base register per operand |
| sh_en | input | NOPS | Shape attached to operand k |
| sh_xd | input | NOPS x DIM_W | x size minus one |
| sh_yd | input | NOPS x DIM_W | y size minus one |
| sh_zd | input | NOPS x DIM_W | z size minus one |
| sh_ord | input | NOPS x 3 | Order code |
| sh_off | input | NOPS x OFF_W | Offset added after wrapping |
| sh_skip | input | NOPS | Drop innermost dimension |
| busy | output | 1 | Not in IDLE |
| valid | output | 1 | Element cycle (RUN) |
| done | output | 1 | One-cycle end of loop |
| step_save | output | STEP_W | Current element step |
| dst_we | output | 1 | Predicated destination write enable |
| idx | output | NOPS x (STEP_W+1) | Remapped offset per operand |
| bad_reg | output | NOPS | Register-file overrun per operand |

## Verification
The assertions assume that every configuration input (`vl`, `maxvl`, `pred`, `is_vec`, bases and shape fields) stays constant from the launching `start` until `done`. They also assume `vl` does not exceed `MAX_VL`. The scalar-source stability and step-increment properties depend on this. The stimulus sets all configuration during IDLE and pulses `start` for a single cycle, and it changes nothing again until `busy` has dropped. Every loop length it uses is within the predicate width.

// File: rtl/vremap_pkg.sv
package vremap_pkg;
    typedef enum logic [1:0] {
        ST_IDLE,
        ST_SEEK,
        ST_RUN,
        ST_FINISH
    } vr_state_e;

    localparam logic [2:0] ORD_Y_FIRST = 3'b010;
endpackage

// File: rtl/vremap_lane.sv
module vremap_lane
    import vremap_pkg::*;
#(
    parameter int DIM_W  = 3,
    parameter int STEP_W = 7,
    parameter int LIN_W  = 3 * DIM_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear,
    input  logic [STEP_W-1:0] load_step,
    input  logic              adv_step,
    input  logic              adv_shape,
    input  logic [DIM_W-1:0]  xd,
    input  logic [DIM_W-1:0]  yd,
    input  logic [DIM_W-1:0]  zd,
    input  logic [2:0]        ord,
    input  logic              skip,
    output logic [STEP_W-1:0] opstep,
    output logic [LIN_W-1:0]  lin
);
    logic [DIM_W-1:0] cx, cy, cz;
    logic [DIM_W-1:0] nx, ny, nz;
    logic             y_in;
    logic [LIN_W-1:0] size_x, size_y, part_x, part_y, part_z;

    assign y_in = (ord == ORD_Y_FIRST);

    // odometer step in the selected order
    always_comb begin
        nx = cx;
        ny = cy;
        nz = cz;
        if (y_in) begin
            if (cy == yd) begin
                ny = '0;
                if (cx == xd) begin
                    nx = '0;
                    nz = (cz == zd) ? '0 : cz + 1'b1;
                end else begin
                    nx = cx + 1'b1;
                end
            end else begin
                ny = cy + 1'b1;
            end
        end else begin
            if (cx == xd) begin
                nx = '0;
                if (cy == yd) begin
                    ny = '0;
                    nz = (cz == zd) ? '0 : cz + 1'b1;
                end else begin
                    ny = cy + 1'b1;
                end
            end else begin
                nx = cx + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cx     <= '0;
            cy     <= '0;
            cz     <= '0;
            opstep <= '0;
        end else if (clear) begin
            cx     <= '0;
            cy     <= '0;
            cz     <= '0;
            opstep <= load_step;
        end else begin
            if (adv_shape) begin
                cx <= nx;
                cy <= ny;
                cz <= nz;
            end
            if (adv_step) begin
                opstep <= opstep + 1'b1;
            end
        end
    end

    // linear position in x-major layout, innermost term dropped on skip
    always_comb begin
        size_x = LIN_W'(xd) + LIN_W'(1);
        size_y = LIN_W'(yd) + LIN_W'(1);
        part_x = (skip && !y_in) ? '0 : LIN_W'(cx);
        part_y = (skip && y_in) ? '0 : LIN_W'(cy) * size_x;
        part_z = LIN_W'(cz) * size_x * size_y;
        lin    = part_x + part_y + part_z;
    end
endmodule

// File: rtl/vremap_index.sv
module vremap_index #(
    parameter int LIN_W  = 9,
    parameter int STEP_W = 7,
    parameter int OFF_W  = 4,
    parameter int REG_W  = 7,
    parameter int NREGS  = 128,
    parameter int OUT_W  = STEP_W + 1
) (
    input  logic              shaped,
    input  logic [LIN_W-1:0]  lin,
    input  logic [STEP_W-1:0] opstep,
    input  logic [OFF_W-1:0]  off,
    input  logic [STEP_W-1:0] maxvl,
    input  logic [REG_W-1:0]  base,
    output logic [OUT_W-1:0]  idx,
    output logic              bad
);
    localparam int MW    = (LIN_W > STEP_W) ? LIN_W : STEP_W;
    localparam int SUM_W = ((REG_W > OUT_W) ? REG_W : OUT_W) + 1;

    logic [MW-1:0]    wrapped;
    logic [SUM_W-1:0] total;

    always_comb begin
        if (maxvl == '0) begin
            wrapped = '0;
        end else begin
            wrapped = MW'(lin) % MW'(maxvl);
        end
        if (shaped) begin
            idx = OUT_W'(wrapped[STEP_W-1:0]) + OUT_W'(off);
        end else begin
            idx = OUT_W'(opstep);
        end
        total = SUM_W'(base) + SUM_W'(idx);
        bad   = (total >= SUM_W'(NREGS));
    end
endmodule

// File: rtl/elem_remap.sv
module elem_remap
    import vremap_pkg::*;
#(
    parameter int NOPS   = 4,
    parameter int DIM_W  = 3,
    parameter int OFF_W  = 4,
    parameter int STEP_W = 7,
    parameter int MAX_VL = 64,
    parameter int REG_W  = 7,
    parameter int NREGS  = 128
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic                             start,
    input  logic [STEP_W-1:0]                resume_step,
    input  logic [STEP_W-1:0]                vl,
    input  logic [STEP_W-1:0]                maxvl,
    input  logic [MAX_VL-1:0]                pred,
    input  logic [NOPS-1:0]                  is_vec,
    input  logic [NOPS-1:0][REG_W-1:0]       base,
    input  logic [NOPS-1:0]                  sh_en,
    input  logic [NOPS-1:0][DIM_W-1:0]       sh_xd,
    input  logic [NOPS-1:0][DIM_W-1:0]       sh_yd,
    input  logic [NOPS-1:0][DIM_W-1:0]       sh_zd,
    input  logic [NOPS-1:0][2:0]             sh_ord,
    input  logic [NOPS-1:0][OFF_W-1:0]       sh_off,
    input  logic [NOPS-1:0]                  sh_skip,
    output logic                             busy,
    output logic                             valid,
    output logic                             done,
    output logic [STEP_W-1:0]                step_save,
    output logic                             dst_we,
    output logic [NOPS-1:0][STEP_W:0]        idx,
    output logic [NOPS-1:0]                  bad_reg
);
    localparam int LIN_W   = 3 * DIM_W;
    localparam int OUT_W   = STEP_W + 1;
    localparam int PRED_IW = (MAX_VL > 1) ? $clog2(MAX_VL) : 1;

    vr_state_e         state, nxt;
    logic [STEP_W-1:0] step, seek_cnt;
    logic              launch, seek_go, run_go;
    logic [NOPS-1:0]   bad_raw;

    // next-state decision
    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE: begin
                if (start) begin
                    if (resume_step >= vl) nxt = ST_FINISH;
                    else if (resume_step != '0) nxt = ST_SEEK;
                    else nxt = ST_RUN;
                end
            end
            ST_SEEK: begin
                if (seek_cnt == STEP_W'(1)) nxt = ST_RUN;
            end
            ST_RUN: begin
                if (!is_vec[0] || (({1'b0, step} + 1'b1) >= {1'b0, vl})) nxt = ST_FINISH;
            end
            ST_FINISH: nxt = ST_IDLE;
            default:   nxt = ST_IDLE;
        endcase
    end

    // state register and loop counters
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state    <= ST_IDLE;
            step     <= '0;
            seek_cnt <= '0;
        end else begin
            state <= nxt;
            if (launch) begin
                step     <= resume_step;
                seek_cnt <= resume_step;
            end else if (seek_go) begin
                seek_cnt <= seek_cnt - 1'b1;
            end else if (run_go) begin
                step <= step + 1'b1;
            end
        end
    end

    assign launch  = (state == ST_IDLE) && start;
    assign seek_go = (state == ST_SEEK);
    assign run_go  = (state == ST_RUN) && (nxt == ST_RUN);

    // outputs
    always_comb begin
        busy      = (state != ST_IDLE);
        valid     = (state == ST_RUN);
        done      = (state == ST_FINISH);
        step_save = step;
        dst_we    = valid && pred[step[PRED_IW-1:0]];
        bad_reg   = valid ? bad_raw : '0;
    end

    for (genvar k = 0; k < NOPS; k++) begin : g_op
        logic [STEP_W-1:0] opstep;
        logic [LIN_W-1:0]  lin;

        vremap_lane #(
            .DIM_W (DIM_W),
            .STEP_W(STEP_W),
            .LIN_W (LIN_W)
        ) u_lane (
            .clk      (clk),
            .rst_n    (rst_n),
            .clear    (launch),
            .load_step(is_vec[k] ? resume_step : '0),
            .adv_step (is_vec[k] && run_go),
            .adv_shape(is_vec[k] && (seek_go || run_go)),
            .xd       (sh_xd[k]),
            .yd       (sh_yd[k]),
            .zd       (sh_zd[k]),
            .ord      (sh_ord[k]),
            .skip     (sh_skip[k]),
            .opstep   (opstep),
            .lin      (lin)
        );

        vremap_index #(
            .LIN_W (LIN_W),
            .STEP_W(STEP_W),
            .OFF_W (OFF_W),
            .REG_W (REG_W),
            .NREGS (NREGS),
            .OUT_W (OUT_W)
        ) u_index (
            .shaped(sh_en[k]),
            .lin   (lin),
            .opstep(opstep),
            .off   (sh_off[k]),
            .maxvl (maxvl),
            .base  (base[k]),
            .idx   (idx[k]),
            .bad   (bad_raw[k])
        );
    end
endmodule

// File: rtl/elem_remap_chk.sv
module elem_remap_chk #(
    parameter int NOPS   = 4,
    parameter int STEP_W = 7
) (
    input logic                      clk,
    input logic                      rst_n,
    input logic [STEP_W-1:0]         vl,
    input logic [NOPS-1:0]           is_vec,
    input logic                      valid,
    input logic                      done,
    input logic [STEP_W-1:0]         step_save,
    input logic                      dst_we,
    input logic [NOPS-1:0][STEP_W:0] idx,
    input logic [NOPS-1:0]           bad_reg
);
    a_r9_we_in_element: assert property (@(posedge clk) disable iff (!rst_n)
        dst_we |-> valid);

    a_r10_bad_in_element: assert property (@(posedge clk) disable iff (!rst_n)
        (|bad_reg) |-> valid);

    a_r2_step_increments: assert property (@(posedge clk) disable iff (!rst_n)
        (valid && $past(valid)) |-> (step_save == $past(step_save) + 1'b1));

    a_r2_step_below_vl: assert property (@(posedge clk) disable iff (!rst_n)
        valid |-> (step_save < vl));

    a_r2_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!valid ##1 !done));

    a_r3_scalar_dest_once: assert property (@(posedge clk) disable iff (!rst_n)
        (valid && !is_vec[0]) |=> !valid);

    for (genvar k = 1; k < NOPS; k++) begin : g_src
        a_r4_scalar_src_stable: assert property (@(posedge clk) disable iff (!rst_n)
            (valid && $past(valid) && !is_vec[k]) |-> $stable(idx[k]));
    end
endmodule

bind elem_remap elem_remap_chk #(
    .NOPS  (NOPS),
    .STEP_W(STEP_W)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .vl       (vl),
    .is_vec   (is_vec),
    .valid    (valid),
    .done     (done),
    .step_save(step_save),
    .dst_we   (dst_we),
    .idx      (idx),
    .bad_reg  (bad_reg)
);

// File: tb/elem_remap_test.sv
module elem_remap_test;
    localparam int CLK_P  = 10;
    localparam int NOPS   = 4;
    localparam int DIM_W  = 3;
    localparam int OFF_W  = 4;
    localparam int STEP_W = 7;
    localparam int MAX_VL = 64;
    localparam int REG_W  = 7;

    logic                        clk = 1'b0;
    logic                        rst_n = 1'b0;
    logic                        start = 1'b0;
    logic [STEP_W-1:0]           resume_step = '0;
    logic [STEP_W-1:0]           vl = '0;
    logic [STEP_W-1:0]           maxvl = '0;
    logic [MAX_VL-1:0]           pred = '0;
    logic [NOPS-1:0]             is_vec = '0;
    logic [NOPS-1:0][REG_W-1:0]  base = '0;
    logic [NOPS-1:0]             sh_en = '0;
    logic [NOPS-1:0][DIM_W-1:0]  sh_xd = '0;
    logic [NOPS-1:0][DIM_W-1:0]  sh_yd = '0;
    logic [NOPS-1:0][DIM_W-1:0]  sh_zd = '0;
    logic [NOPS-1:0][2:0]        sh_ord = '0;
    logic [NOPS-1:0][OFF_W-1:0]  sh_off = '0;
    logic [NOPS-1:0]             sh_skip = '0;
    logic                        busy, valid, done, dst_we;
    logic [STEP_W-1:0]           step_save;
    logic [NOPS-1:0][STEP_W:0]   idx;
    logic [NOPS-1:0]             bad_reg;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    always #(CLK_P / 2) clk = ~clk;

    elem_remap uut (
        .clk(clk), .rst_n(rst_n), .start(start), .resume_step(resume_step),
        .vl(vl), .maxvl(maxvl), .pred(pred), .is_vec(is_vec), .base(base),
        .sh_en(sh_en), .sh_xd(sh_xd), .sh_yd(sh_yd), .sh_zd(sh_zd),
        .sh_ord(sh_ord), .sh_off(sh_off), .sh_skip(sh_skip),
        .busy(busy), .valid(valid), .done(done), .step_save(step_save),
        .dst_we(dst_we), .idx(idx), .bad_reg(bad_reg)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // reference: offset of operand k at its own step count p
    function automatic int ref_idx(input int k, input int p);
        int sx, sy, sz, x, y, z, lin, w;
        bit yf;
        if (!sh_en[k]) return p;
        sx = int'(sh_xd[k]) + 1;
        sy = int'(sh_yd[k]) + 1;
        sz = int'(sh_zd[k]) + 1;
        yf = (sh_ord[k] == 3'b010);
        if (yf) begin
            y = p % sy;
            x = (p / sy) % sx;
        end else begin
            x = p % sx;
            y = (p / sx) % sy;
        end
        z = (p / (sx * sy)) % sz;
        lin = z * sx * sy;
        if (!(sh_skip[k] && !yf)) lin += x;
        if (!(sh_skip[k] && yf)) lin += y * sx;
        w = (maxvl == 0) ? 0 : lin % int'(maxvl);
        return w + int'(sh_off[k]);
    endfunction

    task automatic clear_cfg();
        resume_step = '0;
        pred = '0;
        is_vec = '1;
        base = '0;
        sh_en = '0;
        sh_xd = '0;
        sh_yd = '0;
        sh_zd = '0;
        sh_ord = '0;
        sh_off = '0;
        sh_skip = '0;
    endtask

    // launch one loop and compare every cycle against the model
    task automatic run_loop(input string req);
        int rs, nvl, seeks, nel, total;
        rs = int'(resume_step);
        nvl = int'(vl);
        if (rs >= nvl) begin
            seeks = 0;
            nel = 0;
        end else begin
            seeks = rs;
            nel = is_vec[0] ? (nvl - rs) : 1;
        end
        total = seeks + nel + 1;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        for (int c = 0; c < total; c++) begin
            if (c > 0) @(negedge clk);
            if (c < seeks) begin
                check(!valid && !done, "R11", "seek cycle valid/done", {valid, done}, 0);
            end else if (c < seeks + nel) begin
                int i;
                i = rs + (c - seeks);
                check(valid && !done, req, "element valid", valid, 1);
                check(int'(step_save) == i, "R2", "step_save", step_save, i);
                check(dst_we == pred[i], "R9", "dst_we", dst_we, pred[i]);
                for (int k = 0; k < NOPS; k++) begin
                    int p, e;
                    bit eb;
                    p = is_vec[k] ? i : 0;
                    e = ref_idx(k, p);
                    eb = (int'(base[k]) + e) >= 128;
                    check(int'(idx[k]) == e, req, $sformatf("idx[%0d] step %0d", k, i),
                          idx[k], e);
                    check(bad_reg[k] == eb, "R10", $sformatf("bad_reg[%0d] step %0d", k, i),
                          bad_reg[k], eb);
                end
            end else begin
                check(done && !valid, req, "done cycle", {done, valid}, 2);
            end
        end
        @(negedge clk);
        check(!busy && !done, "R2", "back to idle", {busy, done}, 0);
        @(negedge clk);
    endtask

    initial begin
        #(CLK_P * 100000);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired actual=1 expected=0");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        clear_cfg();
        repeat (3) @(negedge clk);
        check(!busy && !valid && !done, "R1", "reset outputs", {busy, valid, done}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(!busy && !valid && !done, "R1", "idle after reset", {busy, valid, done}, 0);

        // R2 R5 R9: plain sequential loop, no shapes
        clear_cfg();
        vl = 7'd8; maxvl = 7'd8;
        pred = 64'hA5;
        base = {7'd48, 7'd32, 7'd16, 7'd0};
        run_loop("R5");

        // R6 R7 R8: matrix-by-vector style shapes plus a transpose
        clear_cfg();
        vl = 7'd16; maxvl = 7'd16; pred = '1;
        sh_en = 4'b1011;
        sh_xd[0] = 3'd3; sh_yd[0] = 3'd0; sh_ord[0] = 3'b000;
        sh_xd[1] = 3'd3; sh_yd[1] = 3'd3; sh_ord[1] = 3'b010; sh_skip[1] = 1'b1;
        sh_xd[3] = 3'd3; sh_yd[3] = 3'd3; sh_ord[3] = 3'b010;
        base = {7'd100, 7'd8, 7'd0, 7'd4};
        run_loop("R7");

        // R3 R4: scalar destination ends after one element
        clear_cfg();
        vl = 7'd5; maxvl = 7'd8; pred = 64'h1;
        is_vec = 4'b0110;
        run_loop("R3");

        // R4: scalar shaped source with an offset stays fixed
        clear_cfg();
        vl = 7'd6; maxvl = 7'd8; pred = 64'h2A;
        is_vec = 4'b1101;
        sh_en = 4'b0010; sh_xd[1] = 3'd3; sh_off[1] = 4'd3;
        run_loop("R4");

        // R8: 8x8 transpose wrapped by maxvl 20, then offset 5
        clear_cfg();
        vl = 7'd20; maxvl = 7'd20; pred = 64'hF0F0F;
        sh_en = 4'b0001;
        sh_xd[0] = 3'd7; sh_yd[0] = 3'd7; sh_ord[0] = 3'b010; sh_off[0] = 4'd5;
        run_loop("R8");

        // R10: bases near the top of the register file
        clear_cfg();
        vl = 7'd12; maxvl = 7'd12; pred = '1;
        base = {7'd120, 7'd120, 7'd0, 7'd116};
        sh_en = 4'b1000; sh_xd[3] = 3'd1; sh_off[3] = 4'd7;
        run_loop("R10");

        // R6: three-level shapes and a non-listed order code
        clear_cfg();
        vl = 7'd24; maxvl = 7'd24; pred = 64'h00F00F;
        sh_en = 4'b0111;
        sh_xd[0] = 3'd1; sh_yd[0] = 3'd2; sh_zd[0] = 3'd1; sh_ord[0] = 3'b000;
        sh_xd[1] = 3'd1; sh_yd[1] = 3'd2; sh_zd[1] = 3'd1; sh_ord[1] = 3'b010;
        sh_xd[2] = 3'd2; sh_yd[2] = 3'd1; sh_zd[2] = 3'd3; sh_ord[2] = 3'b101;
        run_loop("R6");

        // R11: resume part way through a shaped loop
        clear_cfg();
        vl = 7'd16; maxvl = 7'd16; pred = 64'hBEEF;
        sh_en = 4'b1011;
        sh_xd[0] = 3'd3; sh_ord[0] = 3'b000;
        sh_xd[1] = 3'd3; sh_yd[1] = 3'd3; sh_ord[1] = 3'b010; sh_skip[1] = 1'b1;
        sh_xd[3] = 3'd3; sh_yd[3] = 3'd3; sh_ord[3] = 3'b010; sh_off[3] = 4'd2;
        resume_step = 7'd5;
        run_loop("R11");

        // R11: resume with a scalar destination
        clear_cfg();
        vl = 7'd9; maxvl = 7'd9; pred = 64'h100;
        is_vec = 4'b1110; resume_step = 7'd8;
        run_loop("R11");

        // R11: resume at or past the end goes straight to done
        clear_cfg();
        vl = 7'd4; maxvl = 7'd4;
        resume_step = 7'd4;
        run_loop("R11");

        finished = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule